// File: doc/BRIEF.md
# Word Field Load, Store and Compare Unit

This unit handles partial-word access for a sign-magnitude machine. A word has one sign bit and five 6-bit magnitude bytes. A field code selects a contiguous run of the six positions in the word. Position 0 is the sign, and positions 1 to 5 are the magnitude bytes, from most significant to least significant.

The unit has four operations:
- **Load** right-aligns the selected bytes of a memory word.
- **Negating load** does the same as load, then inverts the sign.
- **Store** merges a register's low bytes into the selected field of a memory word.
- **Compare** compares one field of a register and a memory word, and raises one of less, equal or greater.

Operands are presented with a one-cycle strobe. The result, the flags and a done pulse appear on the next clock edge. Instruction decode, memory access and index arithmetic are handled elsewhere.

Top module: `field_unit`

## Requirements
- R1: A word is laid out with bit 30 as the sign (1 = minus) and magnitude byte k (1..5) at bits [6*(5-k)+5 : 6*(5-k)]. The field code is 8*L+R: bits [5:3] hold L and bits [2:0] hold R. The code is legal only when L <= R <= 5.
- R2: For an illegal field code, `invalid_o` rises together with `done_o`, and both `result_o` and the flags keep their previous values. A legal strobe clears `invalid_o`.
- R3: A load (`op_i` = 0) moves the bytes in positions max(L,1)..R down so that byte R lands in position 5. All higher bytes of the result are zero.
- R4: On a load, the result sign is the memory sign when L = 0 and plus otherwise.
- R5: A negating load (`op_i` = 1) produces the load result of R3 and R4 with its sign inverted.
- R6: A store (`op_i` = 2) returns the memory word with only positions L..R replaced. Field byte k takes register byte k+5-R, and the sign comes from the register when L = 0.
- R7: A compare (`op_i` = 3) takes the same unshifted field from both words and sets exactly one of `lt_o`, `eq_o`, `gt_o`. The comparison is by signed value, register against memory, and the sign is counted only when L = 0.
- R8: A field whose value is zero counts as zero whatever its sign, so +0 and -0 compare equal.
- R9: `done_o` is high exactly in the cycle after a `valid_i` strobe and low otherwise. Reset clears `result_o`, `done_o` and `invalid_o`, and leaves `eq_o` set.
- R10: Loads and stores leave the flags unchanged, and a compare leaves `result_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 2 | 0 load, 1 negating load, 2 store, 3 compare |
| fspec_i | input | 6 | Field code 8*L+R |
| reg_word_i | input | 31 | Register operand |
| mem_word_i | input | 31 | Memory operand |
| result_o | output | 31 | Registered load or store result |
| lt_o | output | 1 | Register field less than memory field |
| eq_o | output | 1 | Fields equal |
| gt_o | output | 1 | Register field greater than memory field |
| invalid_o | output | 1 | Last strobe carried an illegal field code |
| done_o | output | 1 | Result valid pulse |

## Verification
The bench checks these corner cases, and what a wrong design would do in each:
- **Sign-only field (0:0).** A design that mishandles it would leak magnitude bytes into the result.
- **Single-byte fields at either end.** A wrong shift distance would misplace the byte.
- **Stores into inner fields.** A wrong merge mask would clobber the neighbouring bytes.
- **Compares with opposite signs, and a negative register against a zero field.** A plain unsigned comparison would get the ordering wrong.
- **-0 against +0.** A design that did not treat these as equal would report less or greater.
- **Codes with L > R or R > 5.** A design that let them through would overwrite the result.

A sweep over every legal field with changing words checks all four operations against an independent byte-wise model.

// File: rtl/field_pkg.sv
package field_pkg;
  typedef enum logic [1:0] {
    OP_LOAD     = 2'd0,
    OP_LOAD_NEG = 2'd1,
    OP_STORE    = 2'd2,
    OP_CMP      = 2'd3
  } field_op_e;
endpackage

// File: rtl/field_decode.sv
module field_decode #(
  parameter int N_BYTES = 5,
  parameter int POS_W   = 3
) (
  input  logic [2*POS_W-1:0] fspec_i,
  output logic               ok_o,
  output logic               sign_sel_o,
  output logic [N_BYTES-1:0] byte_mask_o, // bit j covers position N_BYTES-j
  output logic [POS_W-1:0]   shift_o      // bytes between R and the low end
);
  logic [POS_W-1:0] l_pos, r_pos;

  assign l_pos      = fspec_i[2*POS_W-1:POS_W];
  assign r_pos      = fspec_i[POS_W-1:0];
  assign ok_o       = (l_pos <= r_pos) && (r_pos <= POS_W'(N_BYTES));
  assign sign_sel_o = ok_o && (l_pos == '0);
  assign shift_o    = POS_W'(N_BYTES) - r_pos;

  for (genvar j = 0; j < N_BYTES; j++) begin : g_mask
    localparam int K = N_BYTES - j;
    assign byte_mask_o[j] = ok_o && (POS_W'(K) >= l_pos) && (POS_W'(K) <= r_pos);
  end
endmodule

// File: rtl/field_load.sv
module field_load #(
  parameter int BYTE_W  = 6,
  parameter int N_BYTES = 5,
  parameter int POS_W   = 3,
  localparam int MAG_W  = BYTE_W * N_BYTES,
  localparam int WORD_W = MAG_W + 1
) (
  input  logic [WORD_W-1:0]  mem_i,
  input  logic [N_BYTES-1:0] byte_mask_i,
  input  logic               sign_sel_i,
  input  logic [POS_W-1:0]   shift_i,
  input  logic               negate_i,
  output logic [WORD_W-1:0]  word_o
);
  logic [MAG_W-1:0] bit_mask, picked, mag;

  for (genvar j = 0; j < N_BYTES; j++) begin : g_bits
    assign bit_mask[j*BYTE_W +: BYTE_W] = {BYTE_W{byte_mask_i[j]}};
  end

  assign picked = mem_i[MAG_W-1:0] & bit_mask;

  always_comb begin
    int sh;
    sh  = int'(shift_i) * BYTE_W;
    mag = picked >> sh;
  end

  assign word_o = {(sign_sel_i & mem_i[MAG_W]) ^ negate_i, mag};

  // R3: alignment keeps every selected bit, so zero-ness is preserved
  always_comb begin
    a_r3_no_bits_lost: assert ((mag != '0) == (picked != '0))
      else $error("load alignment dropped field bits");
  end
endmodule

// File: rtl/field_store.sv
module field_store #(
  parameter int BYTE_W  = 6,
  parameter int N_BYTES = 5,
  parameter int POS_W   = 3,
  localparam int MAG_W  = BYTE_W * N_BYTES,
  localparam int WORD_W = MAG_W + 1
) (
  input  logic [WORD_W-1:0]  reg_i,
  input  logic [WORD_W-1:0]  mem_i,
  input  logic [N_BYTES-1:0] byte_mask_i,
  input  logic               sign_sel_i,
  input  logic [POS_W-1:0]   shift_i,
  output logic [WORD_W-1:0]  word_o
);
  logic [MAG_W-1:0] bit_mask, placed, mag;

  for (genvar j = 0; j < N_BYTES; j++) begin : g_bits
    assign bit_mask[j*BYTE_W +: BYTE_W] = {BYTE_W{byte_mask_i[j]}};
  end

  always_comb begin
    int sh;
    sh     = int'(shift_i) * BYTE_W;
    placed = reg_i[MAG_W-1:0] << sh;
  end

  assign mag    = (mem_i[MAG_W-1:0] & ~bit_mask) | (placed & bit_mask);
  assign word_o = {sign_sel_i ? reg_i[MAG_W] : mem_i[MAG_W], mag};

  // R6: bytes outside the field come through untouched
  always_comb begin
    a_r6_outside_kept: assert ((word_o[MAG_W-1:0] & ~bit_mask) == (mem_i[MAG_W-1:0] & ~bit_mask))
      else $error("store disturbed bytes outside the field");
  end
endmodule

// File: rtl/field_compare.sv
module field_compare #(
  parameter int BYTE_W  = 6,
  parameter int N_BYTES = 5,
  localparam int MAG_W  = BYTE_W * N_BYTES,
  localparam int WORD_W = MAG_W + 1
) (
  input  logic [WORD_W-1:0]  reg_i,
  input  logic [WORD_W-1:0]  mem_i,
  input  logic [N_BYTES-1:0] byte_mask_i,
  input  logic               sign_sel_i,
  output logic               lt_o,
  output logic               eq_o,
  output logic               gt_o
);
  logic [MAG_W-1:0] bit_mask, r_mag, m_mag;
  logic             r_neg, m_neg, mag_lt, mag_eq;

  for (genvar j = 0; j < N_BYTES; j++) begin : g_bits
    assign bit_mask[j*BYTE_W +: BYTE_W] = {BYTE_W{byte_mask_i[j]}};
  end

  assign r_mag = reg_i[MAG_W-1:0] & bit_mask;
  assign m_mag = mem_i[MAG_W-1:0] & bit_mask;
  // a zero magnitude counts as positive, whatever its sign bit
  assign r_neg  = sign_sel_i && reg_i[MAG_W] && (r_mag != '0);
  assign m_neg  = sign_sel_i && mem_i[MAG_W] && (m_mag != '0);
  assign mag_lt = r_mag < m_mag;
  assign mag_eq = r_mag == m_mag;

  always_comb begin
    lt_o = 1'b0;
    eq_o = 1'b0;
    gt_o = 1'b0;
    if (r_neg != m_neg) begin
      lt_o = r_neg;
      gt_o = m_neg;
    end else if (mag_eq) begin
      eq_o = 1'b1;
    end else if (mag_lt ^ r_neg) begin
      lt_o = 1'b1;
    end else begin
      gt_o = 1'b1;
    end
  end

  // R8: two zero fields are equal regardless of sign
  always_comb begin
    a_r8_zero_equal: assert (!((r_mag == '0) && (m_mag == '0)) || eq_o)
      else $error("zero fields not reported equal");
  end
endmodule

// File: rtl/field_unit.sv
module field_unit
  import field_pkg::*;
#(
  parameter int BYTE_W  = 6,
  parameter int N_BYTES = 5,
  localparam int POS_W  = $clog2(N_BYTES + 1),
  localparam int MAG_W  = BYTE_W * N_BYTES,
  localparam int WORD_W = MAG_W + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [1:0]          op_i,
  input  logic [2*POS_W-1:0]  fspec_i,
  input  logic [WORD_W-1:0]   reg_word_i,
  input  logic [WORD_W-1:0]   mem_word_i,
  output logic [WORD_W-1:0]   result_o,
  output logic                lt_o,
  output logic                eq_o,
  output logic                gt_o,
  output logic                invalid_o,
  output logic                done_o
);
  field_op_e            op;
  logic                 ok, sign_sel;
  logic [N_BYTES-1:0]   byte_mask;
  logic [POS_W-1:0]     shift;
  logic [WORD_W-1:0]    load_word, store_word;
  logic                 c_lt, c_eq, c_gt;

  assign op = field_op_e'(op_i);

  field_decode #(.N_BYTES(N_BYTES), .POS_W(POS_W)) u_decode (
    .fspec_i     (fspec_i),
    .ok_o        (ok),
    .sign_sel_o  (sign_sel),
    .byte_mask_o (byte_mask),
    .shift_o     (shift)
  );

  field_load #(.BYTE_W(BYTE_W), .N_BYTES(N_BYTES), .POS_W(POS_W)) u_load (
    .mem_i       (mem_word_i),
    .byte_mask_i (byte_mask),
    .sign_sel_i  (sign_sel),
    .shift_i     (shift),
    .negate_i    (op == OP_LOAD_NEG),
    .word_o      (load_word)
  );

  field_store #(.BYTE_W(BYTE_W), .N_BYTES(N_BYTES), .POS_W(POS_W)) u_store (
    .reg_i       (reg_word_i),
    .mem_i       (mem_word_i),
    .byte_mask_i (byte_mask),
    .sign_sel_i  (sign_sel),
    .shift_i     (shift),
    .word_o      (store_word)
  );

  field_compare #(.BYTE_W(BYTE_W), .N_BYTES(N_BYTES)) u_cmp (
    .reg_i       (reg_word_i),
    .mem_i       (mem_word_i),
    .byte_mask_i (byte_mask),
    .sign_sel_i  (sign_sel),
    .lt_o        (c_lt),
    .eq_o        (c_eq),
    .gt_o        (c_gt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o  <= '0;
      lt_o      <= 1'b0;
      eq_o      <= 1'b1;
      gt_o      <= 1'b0;
      invalid_o <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      done_o <= valid_i;
      if (valid_i) begin
        invalid_o <= !ok;
        if (ok) begin
          unique case (op)
            OP_LOAD, OP_LOAD_NEG: result_o <= load_word;
            OP_STORE:             result_o <= store_word;
            OP_CMP: begin
              lt_o <= c_lt;
              eq_o <= c_eq;
              gt_o <= c_gt;
            end
            default: ;
          endcase
        end
      end
    end
  end

  a_r9_done_after_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> done_o);
  a_r9_no_spurious_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !done_o);
  a_r2_invalid_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !ok) |=> (invalid_o && $stable(result_o) && $stable({lt_o, eq_o, gt_o})));
  a_r7_one_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot({lt_o, eq_o, gt_o}));
  a_r10_flags_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op != OP_CMP) |=> $stable({lt_o, eq_o, gt_o}));
  a_r10_result_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op == OP_CMP) |=> $stable(result_o));
endmodule

// File: tb/field_unit_tb.sv
`timescale 1ns/1ps
module field_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [1:0]  op = '0;
  logic [5:0]  fspec = '0;
  logic [30:0] reg_w = '0, mem_w = '0;
  logic [30:0] result;
  logic        lt, eq, gt, invalid, done;
  int          n_chk = 0, n_bad = 0;
  bit          finished = 0;

  always #4 clk = ~clk;

  field_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .fspec_i(fspec),
    .reg_word_i(reg_w), .mem_word_i(mem_w), .result_o(result),
    .lt_o(lt), .eq_o(eq), .gt_o(gt), .invalid_o(invalid), .done_o(done)
  );

  function automatic logic [5:0] byte_of(logic [30:0] w, int k);
    return w[6*(5-k) +: 6];
  endfunction

  function automatic logic [30:0] m_load(logic [30:0] w, int l, int r, bit neg);
    logic [30:0] res = '0;
    for (int k = (l == 0 ? 1 : l); k <= r; k++) res[6*(r-k) +: 6] = byte_of(w, k);
    res[30] = ((l == 0) ? w[30] : 1'b0) ^ neg;
    return res;
  endfunction

  function automatic logic [30:0] m_store(logic [30:0] rw, logic [30:0] mw, int l, int r);
    logic [30:0] res = mw;
    for (int k = (l == 0 ? 1 : l); k <= r; k++) res[6*(5-k) +: 6] = rw[6*(r-k) +: 6];
    if (l == 0) res[30] = rw[30];
    return res;
  endfunction

  function automatic longint m_val(logic [30:0] w, int l, int r);
    longint v = 0;
    for (int k = (l == 0 ? 1 : l); k <= r; k++) v = v * 64 + longint'(byte_of(w, k));
    if (l == 0 && w[30]) v = -v;
    return v;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(logic [1:0] o, int l, int r, logic [30:0] rw, logic [30:0] mw);
    @(negedge clk);
    op = o; fspec = 6'(8*l + r); reg_w = rw; mem_w = mw; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic do_load(bit neg, int l, int r, logic [30:0] mw, string req);
    logic [30:0] e;
    e = m_load(mw, l, r, neg);
    issue(neg ? 2'd1 : 2'd0, l, r, 31'h0, mw);
    check(done && !invalid, "R9", {30'b0, done, invalid}, 32'h2);
    check(result == e, req, {1'b0, result}, {1'b0, e});
  endtask

  task automatic do_store(int l, int r, logic [30:0] rw, logic [30:0] mw, string req);
    logic [30:0] e;
    e = m_store(rw, mw, l, r);
    issue(2'd2, l, r, rw, mw);
    check(result == e, req, {1'b0, result}, {1'b0, e});
  endtask

  task automatic do_cmp(int l, int r, logic [30:0] rw, logic [30:0] mw, string req);
    longint a, b;
    logic [2:0] e;
    a = m_val(rw, l, r); b = m_val(mw, l, r);
    e = {a < b, a == b, a > b};
    issue(2'd3, l, r, rw, mw);
    check({lt, eq, gt} == e, req, {29'b0, lt, eq, gt}, {29'b0, e});
  endtask

  function automatic logic [30:0] mk(bit s, int b1, int b2, int b3, int b4, int b5);
    return {s, 6'(b1), 6'(b2), 6'(b3), 6'(b4), 6'(b5)};
  endfunction

  task automatic t_reset();
    check(result == '0 && !done && !invalid, "R9", {1'b0, result}, 32'h0);
    check({lt, eq, gt} == 3'b010, "R9", {29'b0, lt, eq, gt}, 32'h2);
  endtask

  task automatic t_load();
    logic [30:0] w;
    w = mk(1, 1, 2, 3, 4, 5);
    do_load(0, 0, 5, w, "R3");
    do_load(0, 1, 5, w, "R4");
    do_load(0, 4, 4, w, "R3");
    do_load(0, 1, 1, w, "R3");
    do_load(0, 2, 3, w, "R3");
    do_load(0, 0, 0, w, "R4");
    do_load(0, 0, 2, w, "R4");
  endtask

  task automatic t_load_neg();
    do_load(1, 0, 5, mk(1, 9, 8, 7, 6, 5), "R5");
    do_load(1, 3, 5, mk(0, 9, 8, 7, 6, 5), "R5");
    do_load(1, 0, 0, mk(0, 1, 1, 1, 1, 1), "R5");
  endtask

  task automatic t_store();
    logic [30:0] m;
    m = mk(0, 10, 11, 12, 13, 14);
    do_store(0, 5, mk(1, 1, 2, 3, 4, 5), m, "R6");
    do_store(2, 3, mk(1, 1, 2, 3, 40, 50), m, "R6");
    do_store(1, 1, mk(1, 0, 0, 0, 0, 63), m, "R6");
    do_store(0, 0, mk(1, 7, 7, 7, 7, 7), m, "R6");
    do_store(5, 5, mk(0, 0, 0, 0, 0, 33), m, "R6");
  endtask

  task automatic t_compare();
    do_cmp(0, 5, mk(0, 0, 0, 0, 0, 5), mk(0, 0, 0, 0, 0, 6), "R7");
    do_cmp(0, 5, mk(1, 0, 0, 0, 0, 5), mk(0, 0, 0, 0, 0, 1), "R7");
    do_cmp(0, 5, mk(1, 0, 0, 0, 0, 5), mk(1, 0, 0, 0, 0, 6), "R7");
    do_cmp(1, 5, mk(1, 0, 0, 0, 0, 5), mk(0, 0, 0, 0, 0, 1), "R7");
    do_cmp(2, 2, mk(0, 9, 3, 1, 1, 1), mk(0, 1, 3, 9, 9, 9), "R7");
    do_cmp(0, 1, mk(1, 0, 9, 9, 9, 9), mk(0, 0, 0, 0, 0, 0), "R7");
  endtask

  task automatic t_zero();
    do_cmp(0, 5, mk(1, 0, 0, 0, 0, 0), mk(0, 0, 0, 0, 0, 0), "R8");
    do_cmp(0, 0, mk(1, 5, 5, 5, 5, 5), mk(0, 1, 1, 1, 1, 1), "R8");
    do_cmp(0, 2, mk(1, 0, 0, 7, 7, 7), mk(0, 0, 0, 3, 3, 3), "R8");
  endtask

  task automatic t_invalid();
    logic [30:0] keep_r;
    logic [2:0]  keep_f;
    do_cmp(0, 5, mk(0, 0, 0, 0, 0, 1), mk(0, 0, 0, 0, 0, 2), "R7");
    do_load(0, 0, 5, mk(0, 4, 4, 4, 4, 4), "R3");
    keep_r = result; keep_f = {lt, eq, gt};
    issue(2'd0, 3, 1, 31'h0, mk(1, 9, 9, 9, 9, 9));
    check(invalid && done && result == keep_r, "R2", {1'b0, result}, {1'b0, keep_r});
    issue(2'd2, 0, 6, mk(1, 9, 9, 9, 9, 9), 31'h0);
    check(invalid && result == keep_r, "R2", {1'b0, result}, {1'b0, keep_r});
    issue(2'd3, 7, 7, 31'h0, mk(1, 9, 9, 9, 9, 9));
    check(invalid && {lt, eq, gt} == keep_f, "R2", {29'b0, lt, eq, gt}, {29'b0, keep_f});
    do_load(0, 5, 5, mk(0, 0, 0, 0, 0, 2), "R2");
    check(!invalid, "R2", {31'b0, invalid}, 32'h0);
  endtask

  task automatic t_keep();
    logic [2:0]  f;
    logic [30:0] r;
    do_cmp(0, 5, mk(0, 0, 0, 0, 0, 9), mk(0, 0, 0, 0, 0, 1), "R7");
    f = {lt, eq, gt};
    do_store(0, 5, mk(1, 0, 0, 0, 0, 0), mk(0, 1, 1, 1, 1, 1), "R6");
    check({lt, eq, gt} == f, "R10", {29'b0, lt, eq, gt}, {29'b0, f});
    r = result;
    do_cmp(0, 5, mk(0, 0, 0, 0, 0, 1), mk(0, 0, 0, 0, 0, 9), "R7");
    check(result == r, "R10", {1'b0, result}, {1'b0, r});
  endtask

  task automatic t_timing();
    issue(2'd0, 0, 5, 31'h0, 31'h1);
    @(negedge clk);
    check(!done, "R9", {31'b0, done}, 32'h0);
  endtask

  task automatic t_sweep();
    logic [30:0] s;
    s = 31'h2A5F_1C3B;
    for (int l = 0; l <= 5; l++) begin
      for (int r = l; r <= 5; r++) begin
        s = {s[29:0], s[30] ^ s[27]} ^ 31'(l * 977 + r * 131);
        do_load(r[0], l, r, s, "R1");
        do_store(l, r, {s[14:0], s[30:15]}, s, "R1");
        do_cmp(l, r, {s[30], s[29:6], ~s[5:0]}, s, "R1");
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_load();
    t_load_neg();
    t_store();
    t_compare();
    t_zero();
    t_invalid();
    t_keep();
    t_timing();
    t_sweep();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule